// File: doc/BRIEF.md
# Burst Opcode Fetch Sequencer

This block fetches one script instruction from memory through a read master that can burst. A one-cycle `start` in the idle state launches a fetch at `start_addr`. The first word that comes back carries a two-bit instruction class in bits [31:30]. The class sets how many 32-bit words the instruction needs and how the reads after the first one are split into separate bus ownerships. When every word has arrived, the assembled words are shown on `out_words`, the word count is shown on `out_count`, and `out_done` pulses for one cycle.

Burst fetching is active only when `burst_en` is 1 and `prefetch_en` is 0. The sequencer latches both inputs at launch. In burst mode the first ownership always reads two words. Each later ownership reads `min(2, words still needed)` words. With burst fetching off, every word is read in its own single-word ownership. Within one instruction, each ownership starts 4 bytes after the last word already received.

The controller has four states. IDLE waits for `start`. OWN holds a request until the read master reports `rd_done`. GAP drops the request for one cycle and decides whether another ownership is needed. DONE shows the result for one cycle. The transitions are:
- IDLE→OWN on `start`.
- OWN→GAP on `rd_done`.
- GAP→OWN while words are missing.
- GAP→DONE once all words are present.
- DONE→IDLE always.

Top module: `opfetch_seq`

## Requirements
- R1: After reset, `rd_req` and `out_done` are 0 and `out_count` is 0.
- R2: A `start` pulse in IDLE launches a fetch. A `start` pulse during a fetch is ignored, and the fetch in progress keeps its address, mode and results.
- R3: In burst mode (`burst_en`=1 and `prefetch_en`=0), the first ownership has `rd_len`=2 at `start_addr`.
- R4: Class 2'b00 (plain) needs 2 words. In burst mode it uses only the first ownership.
- R5: Class 2'b11 (memory-to-memory move) needs 3 words. In burst mode, the third word is read in a second ownership with `rd_len`=1 at `start_addr`+8.
- R6: Class 2'b01 (indirect) needs 3 words. In burst mode, the extra word is read in a second ownership with `rd_len`=1 at `start_addr`+8.
- R7: Class 2'b10 (table-indirect block move) needs 4 words. In burst mode, it uses two ownerships with `rd_len`=2, at `start_addr` and at `start_addr`+8.
- R8: When burst mode is off (`burst_en`=0 or `prefetch_en`=1), every word is read in its own ownership with `rd_len`=1. The addresses are `start_addr`+4·i.
- R9: `rd_req` is low for at least one cycle after every `rd_done`. `rd_addr` and `rd_len` hold steady while a request waits for `rd_done`.
- R10: `out_done` is a one-cycle pulse that follows the arrival of all needed words. During the pulse:
  - word i sits at `out_words[32i+:32]` in arrival order;
  - `out_count` equals the class's word count;
  - unused slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse, taken only in IDLE |
| start_addr | input | AW | Byte address of the first instruction word |
| burst_en | input | 1 | Burst fetch enable |
| prefetch_en | input | 1 | Prefetch active; forces single-word reads |
| rd_req | output | 1 | Read ownership request |
| rd_addr | output | AW | Byte address of the ownership's first word |
| rd_len | output | 2 | Words in this ownership (1 or 2) |
| rd_valid | input | 1 | A read data beat is present |
| rd_data | input | DW | Read data beat |
| rd_done | input | 1 | Last beat of the ownership |
| out_words | output | MAXW*DW | Assembled instruction words |
| out_count | output | CW | Number of valid words |
| out_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong class latch or a wrong word index shows up at the read port within one GAP cycle of the first ownership. The fault appears as a missing, extra or wrongly sized second ownership, or as a shifted `rd_addr`. A broken state register shows up within a few cycles. It either leaves `rd_req` high across an `rd_done`, or holds `out_done` for more than one cycle. The bench sweeps every class against every mode combination. It records each ownership's address and length, and checks the recorded list and the assembled words against values computed from the class table.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN    = 2'b00,
        CLS_INDIRECT = 2'b01,
        CLS_TBLMOVE  = 2'b10,
        CLS_MEMMOVE  = 2'b11
    } insn_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OWN,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    // Words an instruction of each class occupies.
    function automatic logic [2:0] words_for(insn_cls_e cls);
        unique case (cls)
            CLS_PLAIN:    return 3'd2;
            CLS_INDIRECT: return 3'd3;
            CLS_TBLMOVE:  return 3'd4;
            CLS_MEMMOVE:  return 3'd3;
            default:      return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/opfetch_wordbuf.sv
module opfetch_wordbuf
    import opfetch_pkg::*;
#(
    parameter int DW   = 32,
    parameter int MAXW = 4,
    parameter int CW   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                beat_valid,
    input  logic [DW-1:0]       beat_data,
    output logic [MAXW*DW-1:0]  words,
    output logic [CW-1:0]       widx,
    output insn_cls_e           cls
);

    // One holding register per word slot.
    for (genvar i = 0; i < MAXW; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[i*DW +: DW] <= '0;
            end else if (clear) begin
                words[i*DW +: DW] <= '0;
            end else if (beat_valid && widx == CW'(i)) begin
                words[i*DW +: DW] <= beat_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx <= '0;
            cls  <= CLS_PLAIN;
        end else if (clear) begin
            widx <= '0;
            cls  <= CLS_PLAIN;
        end else if (beat_valid && widx < CW'(MAXW)) begin
            widx <= widx + 1'b1;
            if (widx == '0) begin
                cls <= insn_cls_e'(beat_data[DW-1 -: 2]);
            end
        end
    end

endmodule

// File: rtl/opfetch_decode.sv
module opfetch_decode
    import opfetch_pkg::*;
#(
    parameter int CW = 3
) (
    input  insn_cls_e      cls,
    output logic [CW-1:0]  need
);

    always_comb begin
        need = CW'(words_for(cls));
    end

endmodule

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
    import opfetch_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic           burst_en,
    input  logic           prefetch_en,
    input  logic           rd_done,
    input  logic [CW-1:0]  widx,
    input  logic [CW-1:0]  need,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    output logic [1:0]     rd_len,
    output logic           clear,
    output logic           fetch_done
);

    seq_state_e     state, state_nx;
    logic [AW-1:0]  base_q;
    logic           burst_q;
    logic [CW-1:0]  remain;
    logic           more;

    assign remain = need - widx;
    assign more   = widx < need;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = ST_OWN;
            ST_OWN:  if (rd_done) state_nx = ST_GAP;
            ST_GAP:  state_nx = more ? ST_OWN : ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        rd_req     = (state == ST_OWN);
        fetch_done = (state == ST_DONE);
        clear      = (state == ST_IDLE) && start;
    end

    // Ownership address and length, loaded on entry to ST_OWN.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            burst_q <= 1'b0;
            rd_addr <= '0;
            rd_len  <= 2'd1;
        end else if (state == ST_IDLE && start) begin
            base_q  <= start_addr;
            burst_q <= burst_en && !prefetch_en;
            rd_addr <= start_addr;
            rd_len  <= (burst_en && !prefetch_en) ? 2'd2 : 2'd1;
        end else if (state == ST_GAP && more) begin
            rd_addr <= base_q + (AW'(widx) << 2);
            rd_len  <= (burst_q && remain >= CW'(2)) ? 2'd2 : 2'd1;
        end
    end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
    import opfetch_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int MAXW = 4,
    localparam int CW  = $clog2(MAXW + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       start_addr,
    input  logic                burst_en,
    input  logic                prefetch_en,
    output logic                rd_req,
    output logic [AW-1:0]       rd_addr,
    output logic [1:0]          rd_len,
    input  logic                rd_valid,
    input  logic [DW-1:0]       rd_data,
    input  logic                rd_done,
    output logic [MAXW*DW-1:0]  out_words,
    output logic [CW-1:0]       out_count,
    output logic                out_done
);

    logic           clear;
    logic [CW-1:0]  widx;
    logic [CW-1:0]  need;
    insn_cls_e      cls;

    opfetch_wordbuf #(.DW(DW), .MAXW(MAXW), .CW(CW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .beat_valid (rd_valid && rd_req),
        .beat_data  (rd_data),
        .words      (out_words),
        .widx       (widx),
        .cls        (cls)
    );

    opfetch_decode #(.CW(CW)) u_dec (
        .cls  (cls),
        .need (need)
    );

    opfetch_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .burst_en    (burst_en),
        .prefetch_en (prefetch_en),
        .rd_done     (rd_done),
        .widx        (widx),
        .need        (need),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_len      (rd_len),
        .clear       (clear),
        .fetch_done  (out_done)
    );

    // Word count reported with the result; zero until the first word lands.
    assign out_count = (widx == '0) ? '0 : need;

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_req,
    input logic           rd_done,
    input logic [AW-1:0]  rd_addr,
    input logic [1:0]     rd_len,
    input logic           out_done,
    input logic [CW-1:0]  out_count
);

    // R9: a request is dropped after each rd_done.
    p_gap_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_done |=> !rd_req);

    // R9: address and length hold while a request is open.
    p_hold_while_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_done |=> rd_req && $stable(rd_addr) && $stable(rd_len));

    // R3 and R8: a request never asks for zero or more than two words.
    p_len_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_len == 2'd1 || rd_len == 2'd2));

    // R10: the completion flag is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R10: the word count is 2, 3 or 4 whenever the result is shown.
    p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_count >= CW'(2) && out_count <= CW'(4)));

    // R10: no request is open while the result is shown.
    p_idle_bus_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> !rd_req);

endmodule

bind opfetch_seq opfetch_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_done   (rd_done),
    .rd_addr   (rd_addr),
    .rd_len    (rd_len),
    .out_done  (out_done),
    .out_count (out_count)
);

// File: tb/opfetch_seq_tb.sv
module opfetch_seq_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MAXW = 4;
    localparam int CW = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [AW-1:0]       start_addr = '0;
    logic                burst_en = 1'b0;
    logic                prefetch_en = 1'b0;
    logic                rd_req;
    logic [AW-1:0]       rd_addr;
    logic [1:0]          rd_len;
    logic                rd_valid = 1'b0;
    logic [DW-1:0]       rd_data = '0;
    logic                rd_done = 1'b0;
    logic [MAXW*DW-1:0]  out_words;
    logic [CW-1:0]       out_count;
    logic                out_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int own_n;
    int own_len [8];
    logic [AW-1:0] own_addr [8];

    always #2.5 clk = ~clk;

    opfetch_seq #(.AW(AW), .DW(DW), .MAXW(MAXW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .burst_en(burst_en), .prefetch_en(prefetch_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
        .out_words(out_words), .out_count(out_count), .out_done(out_done)
    );

    // Memory image: class bits come from address bits [5:4].
    function automatic logic [31:0] mem(logic [31:0] a);
        return {a[5:4], a[29:0] ^ 30'h1555_5555};
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Read slave: zero-latency beats, records each ownership.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                logic [AW-1:0] a;
                int n;
                a = rd_addr;
                n = int'(rd_len);
                if (own_n < 8) begin
                    own_len[own_n]  = n;
                    own_addr[own_n] = a;
                end
                own_n++;
                for (int b = 0; b < n; b++) begin
                    rd_valid = 1'b1;
                    rd_data  = mem(a + 32'(4 * b));
                    rd_done  = (b == n - 1);
                    @(negedge clk);
                    if (b != n - 1) begin
                        check("R9 hold", {127'b0, rd_req}, 128'd1);
                        check("R9 addr", 128'(rd_addr), 128'(a));
                    end
                end
                rd_valid = 1'b0;
                rd_done  = 1'b0;
                check("R9 gap", {127'b0, rd_req}, 128'd0);
            end
        end
    end

    task automatic run(int cls, bit b, bit pf, int k, bit poke);
        logic [31:0] base;
        int nw, w, i, t;
        bit bm;
        logic [127:0] expw;
        base = 32'h2000 + 32'(k * 256) + 32'(cls * 16);
        nw = (cls == 0) ? 2 : (cls == 2) ? 4 : 3;
        bm = b && !pf;
        own_n = 0;
        @(negedge clk);
        start = 1'b1; start_addr = base; burst_en = b; prefetch_en = pf;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R2: a second launch during the fetch must be ignored.
            start = 1'b1; start_addr = 32'hDEAD_0000; burst_en = !b; prefetch_en = !pf;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!out_done && t < 100) begin
            @(negedge clk);
            t++;
        end
        check("R10 done seen", {127'b0, out_done}, 128'd1);
        check("R10 count", 128'(out_count), 128'(nw));
        expw = '0;
        for (int j = 0; j < nw; j++) expw[j*32 +: 32] = mem(base + 32'(4 * j));
        check(poke ? "R2 words" : "R10 words", out_words, expw);
        // Expected ownership list.
        w = 0; i = 0;
        while (w < nw) begin
            int l;
            l = (bm && (nw - w) >= 2) ? 2 : 1;
            if (i < 8) begin
                if (bm && cls == 0) check("R4 len", 128'(own_len[i]), 128'(l));
                else if (bm && cls == 3) check("R5 len", 128'(own_len[i]), 128'(l));
                else if (bm && cls == 1) check("R6 len", 128'(own_len[i]), 128'(l));
                else if (bm && cls == 2) check("R7 len", 128'(own_len[i]), 128'(l));
                else check("R8 len", 128'(own_len[i]), 128'(l));
                if (i == 0 && bm) check("R3 first addr", 128'(own_addr[i]), 128'(base));
                else check("R8 addr", 128'(own_addr[i]), 128'(base + 32'(4 * w)));
            end
            w += l; i++;
        end
        check("R4 R5 R6 R7 R8 ownerships", 128'(own_n), 128'(i));
        @(negedge clk);
        check("R10 pulse", {127'b0, out_done}, 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 req", {127'b0, rd_req}, 128'd0);
        check("R1 done", {127'b0, out_done}, 128'd0);
        check("R1 count", 128'(out_count), 128'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 4; c++)
                for (int b = 0; b < 2; b++)
                    for (int p = 0; p < 2; p++)
                        run(c, b[0], p[0], k, k[0]);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule